// File: doc/BRIEF.md
# Six-Valued Shared-Net Resolver

This block works out the single value seen on a wire that several sources drive at the same time. Each of the K sources offers one of six values: a strong 0 or 1, a weak 0 or 1, a conflict marker U, or a floating Z. The block reduces them to one net value. It also raises a flag when that value is a conflict. It is used wherever a switch-level or bus-contention model must run in hardware, for example in an emulation fabric that evaluates shared nets once per cycle.

Strength decides the outcome. U beats everything. The strong values beat the weak ones, and the weak values beat Z. Two opposite values at the same strength tier give U; a stronger driver can remove that contention only when the clash is between weak values. The result depends only on which values are present, not on which source carries them. By default the result is captured in an output register, qualified by a valid strobe. A parameter can remove that register.

Top module: `nr_net_resolver`

## Requirements
- R1: Each driver and the net use a 3-bit code: 000 is Z, 001 is weak 0, 010 is weak 1, 011 is strong 0, 100 is strong 1 and 111 is U. A driver code of 101 or 110 is treated as U, and the net output never shows 101 or 110.
- R2: Z loses to every other value. A net whose drivers are all Z resolves to Z (000).
- R3: A strong value overrides weak values of either polarity. For example, strong 1 with weak 0 gives strong 1 (100).
- R4: Strong 0 and strong 1 present together give U (111), whatever weak values are also present.
- R5: Weak 0 and weak 1 present together with no strong driver give U. If exactly one strong polarity is also present, the strong value is the result.
- R6: U on any driver, including the codes 101 and 110, makes the net U.
- R7: The result depends only on the set of values present and not on the driver positions that carry them.
- R8: The conflict flag is 1 exactly when the net output is U.
- R9: With the output register on, a vector presented with in_valid high appears on net_val and conflict on the next clock edge, with out_valid high for that one cycle. While in_valid is low, net_val and conflict hold their values.
- R10: While rst_n is low at a clock edge, out_valid goes to 0, net_val to Z (000) and conflict to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Marks the driver vector as one to resolve |
| drivers | input | 3*K | Driver codes; driver i occupies bits 3i+2..3i |
| out_valid | output | 1 | Net result is new this cycle |
| net_val | output | 3 | Resolved net value code |
| conflict | output | 1 | High when net_val is U |

## Verification
All 64 ordered pairs of codes are placed on two driver positions, with Z on the rest. This covers each strength pairing in both orders and separates a correct strength order from a wired-AND or wired-OR rule. A directed table adds three-driver mixes in which a strong driver settles or fails to settle a weak clash. It also moves single values to the outermost positions and tries the illegal codes. Random full-width vectors, checked against a reference that examines one strength tier at a time, exercise the cases where many drivers combine. Separate tests cover reset and the holding of the output while in_valid is low.

// File: rtl/nr_pkg.sv
// Package: shared value codes and the per-tier presence record.
// Assumes: every module of the resolver uses these codes unchanged.
package nr_pkg;

    localparam int CODE_W = 3;

    typedef enum logic [CODE_W-1:0] {
        NV_Z  = 3'b000,
        NV_W0 = 3'b001,
        NV_W1 = 3'b010,
        NV_S0 = 3'b011,
        NV_S1 = 3'b100,
        NV_U  = 3'b111
    } nv_e;

    // One bit for each class of value seen on the net
    typedef struct packed {
        logic u;
        logic s0;
        logic s1;
        logic w0;
        logic w1;
    } nv_seen_t;

    localparam int SEEN_W = $bits(nv_seen_t);

endpackage

// File: rtl/nr_classify.sv
// Module: maps one driver code to its class bits.
// Assumes: any code outside the five legal non-U values counts as a conflict.
module nr_classify
    import nr_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output nv_seen_t          seen
);

    // Decode the driver code into exactly one class bit (none for Z)
    always_comb begin
        seen = '0;
        case (code)
            NV_Z:    seen = '0;
            NV_W0:   seen.w0 = 1'b1;
            NV_W1:   seen.w1 = 1'b1;
            NV_S0:   seen.s0 = 1'b1;
            NV_S1:   seen.s1 = 1'b1;
            default: seen.u  = 1'b1;
        endcase
    end

endmodule

// File: rtl/nr_seen_merge.sv
// Module: ORs the class bits of K drivers into one presence record.
// Assumes: K >= 1; record i sits in bits SEEN_W*i+SEEN_W-1 .. SEEN_W*i.
module nr_seen_merge
    import nr_pkg::*;
#(
    parameter int K = 8
) (
    input  logic [K*SEEN_W-1:0] seen_vec,
    output nv_seen_t            seen_all
);

    // Accumulate presence across all drivers; OR is order-free by nature
    always_comb begin
        seen_all = '0;
        for (int i = 0; i < K; i++) begin
            seen_all = seen_all | nv_seen_t'(seen_vec[i*SEEN_W +: SEEN_W]);
        end
    end

endmodule

// File: rtl/nr_decide.sv
// Module: turns a presence record into the resolved net code.
// Assumes: record comes from nr_seen_merge; output is always a legal code.
module nr_decide
    import nr_pkg::*;
(
    input  nv_seen_t          seen,
    output logic [CODE_W-1:0] code,
    output logic              is_conf
);

    // Walk the strength tiers from strongest to weakest
    always_comb begin
        if (seen.u || (seen.s0 && seen.s1)) begin
            code = NV_U;
        end else if (seen.s1) begin
            code = NV_S1;
        end else if (seen.s0) begin
            code = NV_S0;
        end else if (seen.w0 && seen.w1) begin
            code = NV_U;
        end else if (seen.w1) begin
            code = NV_W1;
        end else if (seen.w0) begin
            code = NV_W0;
        end else begin
            code = NV_Z;
        end
    end

    // Conflict flag comes straight from the tier checks
    always_comb begin
        is_conf = seen.u || (seen.s0 && seen.s1)
                  || (!seen.s0 && !seen.s1 && seen.w0 && seen.w1);
    end

endmodule

// File: rtl/nr_net_resolver.sv
// Module: top of the six-valued shared-net resolver.
// Assumes: K >= 1; REG_OUT=1 adds a one-cycle output register, 0 is combinational.
module nr_net_resolver
    import nr_pkg::*;
#(
    parameter int K       = 8,
    parameter bit REG_OUT = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [K*3-1:0]    drivers,
    output logic              out_valid,
    output logic [2:0]        net_val,
    output logic              conflict
);

    localparam int SEEN_BITS = K * SEEN_W;

    logic [SEEN_BITS-1:0] seen_vec;
    nv_seen_t             seen_all;
    logic [CODE_W-1:0]    res_code;
    logic                 res_conf;

    // One classifier per driver
    for (genvar g = 0; g < K; g++) begin : g_cls
        nv_seen_t seen_one;
        nr_classify u_cls (
            .code (drivers[g*CODE_W +: CODE_W]),
            .seen (seen_one)
        );
        assign seen_vec[g*SEEN_W +: SEEN_W] = seen_one;
    end

    nr_seen_merge #(.K(K)) u_merge (
        .seen_vec (seen_vec),
        .seen_all (seen_all)
    );

    nr_decide u_decide (
        .seen    (seen_all),
        .code    (res_code),
        .is_conf (res_conf)
    );

    if (REG_OUT) begin : g_reg
        logic              vld_q;
        logic [CODE_W-1:0] val_q;
        logic              conf_q;

        // Capture the result on a valid vector; hold it otherwise
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q  <= 1'b0;
                val_q  <= NV_Z;
                conf_q <= 1'b0;
            end else begin
                vld_q <= in_valid;
                if (in_valid) begin
                    val_q  <= res_code;
                    conf_q <= res_conf;
                end
            end
        end

        assign out_valid = vld_q;
        assign net_val   = val_q;
        assign conflict  = conf_q;

        AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
            (net_val != 3'b101) && (net_val != 3'b110)); // R1
        AST_FLAG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
            conflict == (net_val == NV_U)); // R8
        AST_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
            in_valid |=> out_valid); // R9
        AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
            !in_valid |=> ($stable(net_val) && $stable(conflict) && !out_valid)); // R9
        AST_U_DOMINATES: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && seen_all.u) |=> (net_val == NV_U)); // R6
        AST_ALL_Z: assert property (@(posedge clk) disable iff (!rst_n)
            (in_valid && (drivers == '0)) |=> (net_val == NV_Z)); // R2
    end else begin : g_comb
        assign out_valid = in_valid;
        assign net_val   = res_code;
        assign conflict  = res_conf;
    end

endmodule

// File: tb/nr_net_resolver_tb_top.sv
// Bench: table walk, exhaustive pairs, random vectors, reset and hold tests.
module nr_net_resolver_tb_top;

    localparam int K = 8;
    localparam int NTAB = 14;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           in_valid = 1'b0;
    logic [K*3-1:0] drivers = '0;
    logic           out_valid;
    logic [2:0]     net_val;
    logic           conflict;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    nr_net_resolver #(.K(K), .REG_OUT(1'b1)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .drivers   (drivers),
        .out_valid (out_valid),
        .net_val   (net_val),
        .conflict  (conflict)
    );

    // Directed vectors: octal digit i is driver i
    localparam logic [K*3-1:0] TAB_IN [NTAB] = '{
        24'o00000000, 24'o00000001, 24'o00000042, 24'o00000041,
        24'o00000031, 24'o00000043, 24'o00000021, 24'o00004021,
        24'o00003021, 24'o00000700, 24'o00000500, 24'o00600000,
        24'o40000000, 24'o22222222
    };
    localparam logic [2:0] TAB_EXP [NTAB] = '{
        3'd0, 3'd1, 3'd4, 3'd4,
        3'd3, 3'd7, 3'd7, 3'd4,
        3'd3, 3'd7, 3'd7, 3'd7,
        3'd4, 3'd2
    };

    // Reference: examine the conflict tier, then strong, then weak
    function automatic logic [2:0] ref_net(input logic [K*3-1:0] d);
        bit any_u = 0, has_s0 = 0, has_s1 = 0, has_w0 = 0, has_w1 = 0;
        for (int i = 0; i < K; i++) begin
            logic [2:0] c = d[i*3 +: 3];
            if (c == 3'd5 || c == 3'd6 || c == 3'd7) any_u = 1;
        end
        if (any_u) return 3'd7;
        for (int i = 0; i < K; i++) begin
            if (d[i*3 +: 3] == 3'd3) has_s0 = 1;
            if (d[i*3 +: 3] == 3'd4) has_s1 = 1;
        end
        if (has_s0 && has_s1) return 3'd7;
        if (has_s1) return 3'd4;
        if (has_s0) return 3'd3;
        for (int i = 0; i < K; i++) begin
            if (d[i*3 +: 3] == 3'd1) has_w0 = 1;
            if (d[i*3 +: 3] == 3'd2) has_w1 = 1;
        end
        if (has_w0 && has_w1) return 3'd7;
        if (has_w1) return 3'd2;
        if (has_w0) return 3'd1;
        return 3'd0;
    endfunction

    task automatic check(input string req, input logic [3:0] got, input logic [3:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // Present one vector, then check value, flag and strobe (R8, R9)
    task automatic apply(input logic [K*3-1:0] v, input logic [2:0] exp, input string req);
        @(negedge clk);
        drivers  = v;
        in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        check(req, {1'b0, net_val}, {1'b0, exp});
        check("R8 flag", {3'b0, conflict}, {3'b0, (exp == 3'd7)});
        check("R9 strobe", {3'b0, out_valid}, 4'd1);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        // R10: reset state
        check("R10 valid", {3'b0, out_valid}, 4'd0);
        check("R10 net", {1'b0, net_val}, 4'd0);
        check("R10 flag", {3'b0, conflict}, 4'd0);
        rst_n = 1'b1;

        // Table walk covering R2..R6, R1 illegal codes, R7 positions
        for (int t = 0; t < NTAB; t++) begin
            apply(TAB_IN[t], TAB_EXP[t], "R2-table");
        end

        // Exhaustive ordered pairs on positions 2 and 6 (R3, R4, R5, R6)
        for (int a = 0; a < 8; a++) begin
            for (int b = 0; b < 8; b++) begin
                logic [K*3-1:0] v = '0;
                v[2*3 +: 3] = 3'(a);
                v[6*3 +: 3] = 3'(b);
                apply(v, ref_net(v), "R4_R5 pair");
            end
        end

        // R7: same set of values, reversed driver order
        begin
            logic [K*3-1:0] f = 24'o12340000;
            logic [K*3-1:0] r = 24'o00004321;
            apply(f, 3'd7, "R7 forward");
            apply(r, 3'd7, "R7 reversed");
            apply(24'o00010200, 3'd7, "R7 weak pair a");
            apply(24'o00020100, 3'd7, "R7 weak pair b");
        end

        // Random full-width vectors against the reference (R7, R3)
        for (int n = 0; n < 300; n++) begin
            logic [K*3-1:0] v = '0;
            for (int i = 0; i < K; i++) begin
                int pick = $urandom_range(0, 9);
                v[i*3 +: 3] = (pick < 4) ? 3'd0 : (pick < 6) ? 3'(pick - 3)
                            : (pick < 8) ? 3'(pick - 3) : (pick == 8) ? 3'(pick - 6) : 3'd7;
            end
            apply(v, ref_net(v), "R7 random");
        end

        // R9: hold while in_valid is low
        apply(24'o00000004, 3'd4, "R9 load");
        @(negedge clk);
        drivers = 24'o00000003;
        @(negedge clk);
        check("R9 hold net", {1'b0, net_val}, 4'd4);
        check("R9 hold strobe", {3'b0, out_valid}, 4'd0);

        // R10: reset after activity
        apply(24'o00000007, 3'd7, "R6 before reset");
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 net after", {1'b0, net_val}, 4'd0);
        check("R10 flag after", {3'b0, conflict}, 4'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule